// File: doc/BRIEF.md
# Chained-Table Cycle-Stealing DMA Channel

This block is a single direct memory channel. It moves a block of 16-bit words between a memory port and one I/O device without help from the processor. A start command gives the channel the address of a table in memory. The channel reads a header word from that table. The header carries two scan-control bits, which are passed to the device, and a word count. After that, each time the device says it is ready, the channel takes one memory cycle and moves one data word. After each word the address register steps up by one and the count register steps down by one.

The scan-control bits decide what happens when the count runs out. The channel can stop, or it can follow a link word that sits just after the last data word to the next table. Each linked table begins with a word that holds its own address plus one. The channel checks that word against its incremented address register. If the two differ, the channel aborts and raises an error flag. A stop command from the program ends any transfer at once. The memory is reached through a simple request/grant port: the read data is valid, and a write is taken, in the cycle where `mem_gnt` is high.

Top module: `chain_dma_chan`

## Requirements
- R1: After reset `busy`, `mem_req`, `dev_strobe`, `irq`, `sc_valid` and `chk_err` are all low.
- R2: A `start` pulse while idle makes the next cycle request a memory read at `start_addr`. Every header read pulses `sc_valid` one cycle after its grant and drives bits 15:14 of the header onto `sc_out`. Bits 13:0 of the header are the word count.
- R3: Each data word uses exactly one granted memory cycle. That cycle is issued only after `dev_rdy`, at consecutive addresses after the header. The number of words equals the header count.
- R4: `start_dir` is sampled only when a start is accepted. A value of 1 writes device data (`dev_wdata`) to memory. A value of 0 reads memory and presents each word on `dev_rdata` together with a `dev_strobe` pulse. Later changes of `start_dir` have no effect until the next accepted start.
- R5: Header bit 15 = 0 ends the transfer when the count is exhausted. Bit 14 = 0 then pulses `irq` once; bit 14 = 1 ends with no interrupt.
- R6: Header bit 15 = 1 chains when the count is exhausted, pulsing `irq` only if bit 14 = 0. The chain reads the word after the last data word as the next table address. It then reads that table's first word as a check word, then reads the header after it.
- R7: If the check word differs from the next table address plus one, `chk_err` sets, `busy` drops and no further memory request is made. `chk_err` clears at the next accepted start.
- R8: A header count of zero moves no data and goes straight to the stop or chain handling of R5/R6.
- R9: A `stop` pulse ends any transfer: in the following cycle `busy` and `mem_req` are low, and they stay low until the next start.
- R10: A `start` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only when idle |
| start_addr | input | AW | Address of the first table |
| start_dir | input | 1 | 1: device to memory, 0: memory to device |
| stop | input | 1 | Abort pulse |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_gnt | input | 1 | Request granted this cycle |
| mem_rdata | input | DW | Read data, valid with grant |
| dev_rdy | input | 1 | Device ready for one word |
| dev_wdata | input | DW | Word from the device |
| dev_rdata | output | DW | Word to the device |
| dev_strobe | output | 1 | One word transferred |
| sc_out | output | 2 | Scan-control bits of the current table |
| sc_valid | output | 1 | Pulse when `sc_out` is reloaded |
| irq | output | 1 | End-of-table interrupt pulse |
| chk_err | output | 1 | Chaining-check failure flag |
| busy | output | 1 | Transfer in progress |

## Verification
The hardest cases to reach are a corrupted chain link and a zero-count header that sits in the middle of a chain. Both need a table layout in memory that is built on purpose, and they only matter when the grants come at uneven times. The bench builds chains of one to three tables in a model memory. Table counts and gaps between tables are random. On request, it forces the first count to zero or puts a wrong check word into a chosen table. Grants and device readiness are random. While a run is in progress, `start` and `start_dir` are toggled to show that they are ignored.

// File: rtl/cdma_pkg.sv
package cdma_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_HDR, S_WAIT, S_XFER, S_LINK, S_CHK
  } cstate_t;

  // Scan-control pair from a table header: [1] chain, [0] suppress interrupt
  typedef struct packed {
    logic chain;
    logic quiet;
  } scan_t;
endpackage

// File: rtl/cdma_car.sv
module cdma_car #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_start,
  input  logic [AW-1:0] start_val,
  input  logic          ld_link,
  input  logic [AW-1:0] link_val,
  input  logic          inc,
  output logic [AW-1:0] car_q
);
  logic [AW-1:0] car_d;

  always_comb begin
    car_d = car_q;
    if (ld_start)     car_d = start_val;
    else if (ld_link) car_d = link_val;
    else if (inc)     car_d = car_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) car_q <= '0;
    else        car_q <= car_d;
  end
endmodule

// File: rtl/cdma_wcnt.sv
module cdma_wcnt #(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  input  logic          dec,
  output logic [CW-1:0] cnt_q,
  output logic          last
);
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (ld)       cnt_d = ld_val;
    else if (dec) cnt_d = cnt_q - CW'(1);
  end

  assign last = (cnt_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cdma_seq.sv
module cdma_seq
  import cdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_dir,
  input  logic          stop,
  input  logic          mem_gnt,
  input  logic [DW-1:0] mem_rdata,
  input  logic          dev_rdy,
  input  logic [AW-1:0] car_q,
  input  logic          cnt_last,
  output logic          car_ld_start,
  output logic          car_ld_link,
  output logic          car_inc,
  output logic          cnt_ld,
  output logic          cnt_dec,
  output logic          mem_req,
  output logic          mem_we,
  output logic          busy,
  output logic          dir_q,
  output scan_t         sc_q,
  output logic          sc_valid,
  output logic          irq,
  output logic          strobe,
  output logic          err_q,
  output logic [DW-1:0] rbuf_q
);
  localparam int CW = DW - 2;

  cstate_t       state_q, state_d;
  scan_t         hdr_sc, end_sc;
  logic          hdr_zero, self_ok, end_now;
  logic          sc_ld_en, xfer_ok, err_set, irq_d;
  logic [AW-1:0] car_nx;

  assign hdr_sc   = scan_t'(mem_rdata[DW-1:DW-2]);
  assign hdr_zero = (mem_rdata[CW-1:0] == '0);
  assign car_nx   = car_q + AW'(1);
  assign self_ok  = (mem_rdata == DW'(car_nx));

  always_comb begin
    state_d      = state_q;
    car_ld_start = 1'b0;
    car_ld_link  = 1'b0;
    car_inc      = 1'b0;
    cnt_ld       = 1'b0;
    cnt_dec      = 1'b0;
    sc_ld_en     = 1'b0;
    xfer_ok      = 1'b0;
    err_set      = 1'b0;
    end_now      = 1'b0;
    end_sc       = sc_q;
    unique case (state_q)
      S_IDLE: if (start) begin
        car_ld_start = 1'b1;
        state_d      = S_HDR;
      end
      S_HDR: if (mem_gnt) begin
        car_inc  = 1'b1;
        cnt_ld   = 1'b1;
        sc_ld_en = 1'b1;
        if (hdr_zero) begin
          end_now = 1'b1;
          end_sc  = hdr_sc;
        end else begin
          state_d = S_WAIT;
        end
      end
      S_WAIT: if (dev_rdy) state_d = S_XFER;
      S_XFER: if (mem_gnt) begin
        car_inc = 1'b1;
        cnt_dec = 1'b1;
        xfer_ok = 1'b1;
        if (cnt_last) end_now = 1'b1;
        else          state_d = S_WAIT;
      end
      S_LINK: if (mem_gnt) begin
        car_ld_link = 1'b1;
        state_d     = S_CHK;
      end
      S_CHK: if (mem_gnt) begin
        car_inc = 1'b1;
        if (self_ok) begin
          state_d = S_HDR;
        end else begin
          err_set = 1'b1;
          state_d = S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
    if (end_now) state_d = end_sc.chain ? S_LINK : S_IDLE;
    irq_d = end_now && !end_sc.quiet;
    if (stop) begin
      state_d      = S_IDLE;
      car_ld_start = 1'b0;
      car_ld_link  = 1'b0;
      car_inc      = 1'b0;
      cnt_ld       = 1'b0;
      cnt_dec      = 1'b0;
      sc_ld_en     = 1'b0;
      xfer_ok      = 1'b0;
      err_set      = 1'b0;
      irq_d        = 1'b0;
    end
  end

  assign busy    = (state_q != S_IDLE);
  assign mem_req = (state_q == S_HDR) || (state_q == S_XFER) ||
                   (state_q == S_LINK) || (state_q == S_CHK);
  assign mem_we  = (state_q == S_XFER) && dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      dir_q    <= 1'b0;
      sc_q     <= '0;
      err_q    <= 1'b0;
      irq      <= 1'b0;
      strobe   <= 1'b0;
      sc_valid <= 1'b0;
      rbuf_q   <= '0;
    end else begin
      state_q  <= state_d;
      irq      <= irq_d;
      strobe   <= xfer_ok;
      sc_valid <= sc_ld_en;
      if (car_ld_start) dir_q <= start_dir;
      if (sc_ld_en)     sc_q  <= hdr_sc;
      if (car_ld_start) err_q <= 1'b0;
      else if (err_set) err_q <= 1'b1;
      if (xfer_ok && !dir_q) rbuf_q <= mem_rdata;
    end
  end
endmodule

// File: rtl/chain_dma_chan.sv
module chain_dma_chan
  import cdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic          start_dir,
  input  logic          stop,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_gnt,
  input  logic [DW-1:0] mem_rdata,
  input  logic          dev_rdy,
  input  logic [DW-1:0] dev_wdata,
  output logic [DW-1:0] dev_rdata,
  output logic          dev_strobe,
  output logic [1:0]    sc_out,
  output logic          sc_valid,
  output logic          irq,
  output logic          chk_err,
  output logic          busy
);
  localparam int CW = DW - 2;

  logic [1:0]    rs_q;
  logic          rst_sync_n;
  logic [AW-1:0] car_q;
  logic [CW-1:0] cnt_q;
  logic          cnt_last, dir_q;
  logic          car_ld_start, car_ld_link, car_inc, cnt_ld, cnt_dec;
  scan_t         sc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  cdma_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .start(start), .start_dir(start_dir),
    .stop(stop), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .dev_rdy(dev_rdy),
    .car_q(car_q), .cnt_last(cnt_last), .car_ld_start(car_ld_start),
    .car_ld_link(car_ld_link), .car_inc(car_inc), .cnt_ld(cnt_ld),
    .cnt_dec(cnt_dec), .mem_req(mem_req), .mem_we(mem_we), .busy(busy),
    .dir_q(dir_q), .sc_q(sc_q), .sc_valid(sc_valid), .irq(irq),
    .strobe(dev_strobe), .err_q(chk_err), .rbuf_q(dev_rdata)
  );

  cdma_car #(.AW(AW)) u_car (
    .clk(clk), .rst_n(rst_sync_n), .ld_start(car_ld_start),
    .start_val(start_addr), .ld_link(car_ld_link),
    .link_val(mem_rdata[AW-1:0]), .inc(car_inc), .car_q(car_q)
  );

  cdma_wcnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .ld(cnt_ld), .ld_val(mem_rdata[CW-1:0]),
    .dec(cnt_dec), .cnt_q(cnt_q), .last(cnt_last)
  );

  assign mem_addr  = car_q;
  assign mem_wdata = dev_wdata;
  assign sc_out    = sc_q;
endmodule

// File: rtl/cdma_check.sv
module cdma_check #(
  parameter int AW = 16,
  parameter int CW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [AW-1:0] start_addr,
  input logic          stop,
  input logic          busy,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_gnt,
  input logic [AW-1:0] mem_addr,
  input logic          dev_strobe,
  input logic          sc_valid,
  input logic          irq,
  input logic          chk_err,
  input logic [AW-1:0] car,
  input logic [CW-1:0] cnt,
  input logic          dir
);
  p_hdr_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !stop) |=> (mem_req && !mem_we && mem_addr == $past(start_addr)));

  p_sc_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sc_valid |-> $past(mem_req && mem_gnt && !mem_we));

  p_word_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dev_strobe |-> (car == $past(car) + AW'(1) && cnt == $past(cnt) - CW'(1)));

  p_dir_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (dir == $past(dir)));

  p_irq_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cnt == '0));

  p_err_halts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chk_err) |-> (!busy && !mem_req));

  p_stop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!mem_req && !busy));
endmodule

bind chain_dma_chan cdma_check #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .start(start), .start_addr(start_addr),
  .stop(stop), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
  .mem_gnt(mem_gnt), .mem_addr(mem_addr), .dev_strobe(dev_strobe),
  .sc_valid(sc_valid), .irq(irq), .chk_err(chk_err), .car(car_q),
  .cnt(cnt_q), .dir(dir_q)
);

// File: tb/test_chain_dma_chan.sv
module test_chain_dma_chan;
  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk, rst_n, start, start_dir, stop;
  logic [AW-1:0] start_addr, mem_addr;
  logic          mem_req, mem_we, mem_gnt, dev_rdy, dev_strobe;
  logic [DW-1:0] mem_wdata, mem_rdata, dev_wdata, dev_rdata;
  logic [1:0]    sc_out;
  logic          sc_valid, irq, chk_err, busy;

  chain_dma_chan #(.AW(AW), .DW(DW)) i_chain_dma_chan (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .start_dir(start_dir), .stop(stop), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
    .mem_rdata(mem_rdata), .dev_rdy(dev_rdy), .dev_wdata(dev_wdata),
    .dev_rdata(dev_rdata), .dev_strobe(dev_strobe), .sc_out(sc_out),
    .sc_valid(sc_valid), .irq(irq), .chk_err(chk_err), .busy(busy)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  logic [15:0] mem [0:4095];
  int ncmp = 0, nbad = 0;
  int nstb, irqn, scn;
  logic [15:0] rx [0:255];
  logic [1:0]  scl [0:15];
  int exp_addr [0:255];
  logic [1:0]  exp_sc [0:15];
  int nexp, nsc, nirq, experr;
  logic [15:0] dev0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    ncmp++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // memory, device and output monitor, all acting away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_gnt = 1'b0;
      dev_rdy = 1'b0;
    end else begin
      mem_gnt   = mem_req && (($urandom % 4) != 0);
      mem_rdata = mem[mem_addr[11:0]];
      if (mem_gnt && mem_we) mem[mem_addr[11:0]] = mem_wdata;
      dev_rdy = (($urandom % 3) == 0);
      if (dev_strobe) begin
        if (nstb < 256) rx[nstb] = dev_rdata;
        nstb++;
        dev_wdata = dev_wdata + 16'd1;
      end
      if (irq) irqn++;
      if (sc_valid) begin
        if (scn < 16) scl[scn] = sc_out;
        scn++;
      end
    end
  end

  // Build a chain of tables; c0 forces the first count, q0 the first quiet bit,
  // bad names a table whose check word is corrupted.
  task automatic make_chain(input int ntab, input int bad, input int c0,
                            input int q0, output int base);
    int pos, cnt, stopped;
    logic chain, quiet;
    base = 16 + ($urandom % 3000);
    pos = base; nexp = 0; nsc = 0; nirq = 0; experr = 0; stopped = 0;
    for (int k = 0; k < ntab; k++) begin
      if (k > 0) begin
        mem[pos] = 16'(pos + ((k == bad) ? 2 : 1));
        if (k == bad && stopped == 0) begin experr = 1; stopped = 1; end
        pos++;
      end
      cnt   = (k == 0 && c0 >= 0) ? c0 : int'($urandom % 6);
      chain = (k < ntab - 1);
      quiet = (k == 0 && q0 >= 0) ? q0[0] : 1'($urandom % 2);
      mem[pos] = {chain, quiet, 14'(cnt)};
      pos++;
      if (stopped == 0) begin
        exp_sc[nsc] = {chain, quiet}; nsc++;
        if (!quiet) nirq++;
      end
      for (int i = 0; i < cnt; i++) begin
        mem[pos] = 16'($urandom);
        if (stopped == 0) begin exp_addr[nexp] = pos; nexp++; end
        pos++;
      end
      if (chain) begin
        mem[pos] = 16'(pos + 1 + int'($urandom % 4));
        pos = int'(mem[pos]);
      end
    end
  endtask

  task automatic run_job(input int addr, input logic dir, input bit poke);
    int n;
    nstb = 0; irqn = 0; scn = 0; dev0 = dev_wdata;
    @(negedge clk);
    start = 1'b1; start_addr = AW'(addr); start_dir = dir;
    @(negedge clk);
    start = 1'b0;
    check("R2 header request", {mem_req, mem_we}, 2'b10);
    check("R2 header address", 32'(mem_addr), 32'(addr));
    n = 0;
    while (busy && n < 4000) begin
      if (poke) begin
        start_dir  = 1'($urandom);
        start_addr = AW'($urandom);
        start      = ((n % 5) == 4);
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    check("R3 run finishes", 32'(n < 4000), 32'd1);
    repeat (2) @(negedge clk);
    check("R3 word count", 32'(nstb), 32'(nexp));
    for (int i = 0; i < nexp && i < 256; i++) begin
      if (dir == 1'b0) check("R4 word to device", 32'(rx[i]), 32'(mem[exp_addr[i][11:0]]));
      else             check("R4 word to memory", 32'(mem[exp_addr[i][11:0]]), 32'(16'(dev0 + 16'(i))));
    end
    check("R5/R6 interrupt count", 32'(irqn), 32'(nirq));
    check("R2 scan-control loads", 32'(scn), 32'(nsc));
    for (int i = 0; i < nsc && i < 16; i++) check("R2 scan-control value", 32'(scl[i]), 32'(exp_sc[i]));
    check("R7 check flag", 32'(chk_err), 32'(experr));
    check("R10 idle after run", 32'(busy), 32'd0);
  endtask

  initial begin
    int a, hits, snap;
    void'($urandom(32'd2024));
    rst_n = 1'b0; start = 1'b0; stop = 1'b0; start_dir = 1'b0;
    start_addr = '0; dev_wdata = 16'h4000; mem_rdata = '0;
    mem_gnt = 1'b0; dev_rdy = 1'b0; nstb = 0; irqn = 0; scn = 0;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {busy, mem_req, dev_strobe, irq, sc_valid, chk_err}, 6'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", {busy, mem_req, chk_err}, 3'b0);

    // R5: single table, interrupt, memory to device
    make_chain(1, -1, 5, 0, a); run_job(a, 1'b0, 1'b0);
    // R5: single table, quiet, device to memory
    make_chain(1, -1, 4, 1, a); run_job(a, 1'b1, 1'b0);
    // R8: zero count, stop with interrupt
    make_chain(1, -1, 0, 0, a); run_job(a, 1'b0, 1'b0);
    // R8/R6: zero count in a quiet chaining header
    make_chain(2, -1, 0, 1, a); run_job(a, 1'b1, 1'b0);
    // R6: three linked tables
    make_chain(3, -1, 3, 0, a); run_job(a, 1'b0, 1'b0);
    // R7: broken link in the second table, then a clean run clears the flag
    make_chain(3, 1, 2, 0, a); run_job(a, 1'b1, 1'b0);
    make_chain(1, -1, 2, 1, a); run_job(a, 1'b0, 1'b0);

    // R9: stop in the middle of a long table
    make_chain(1, -1, 40, 0, a);
    nstb = 0;
    @(negedge clk); start = 1'b1; start_addr = AW'(a); start_dir = 1'b0;
    @(negedge clk); start = 1'b0;
    hits = 0;
    while (nstb < 4 && hits < 2000) begin @(negedge clk); hits++; end
    stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    check("R9 stop ends transfer", {busy, mem_req}, 2'b00);
    snap = nstb; hits = 0;
    repeat (30) begin @(negedge clk); if (mem_req || busy) hits++; end
    check("R9 no requests after stop", 32'(hits), 32'd0);
    check("R9 no words after stop", 32'(nstb), 32'(snap));

    // R10/R4: random chains with start and direction toggled mid-run
    for (int j = 0; j < 14; j++) begin
      int nt, bd;
      nt = 1 + int'($urandom % 3);
      bd = (nt > 1 && ($urandom % 4) == 0) ? 1 + int'($urandom % (nt - 1)) : -1;
      make_chain(nt, bd, -1, -1, a);
      run_job(a, 1'($urandom), 1'b1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    ncmp++; nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end
endmodule